// File: doc/BRIEF.md
# Asynchronous Static Memory Cycle Generator

This block turns single read or write requests from an internal valid/ready port into strobe sequences on an asynchronous external memory bus. The bus is non-page and non-multiplexed, 16 bits wide, and timed from a reference clock that equals the core clock. It serves one chip-select region. A request is accepted only while the sequencer is idle. On the accepting clock edge the address and write data are latched, and the chip-select and address-valid strobes fall on that same edge.

Each strobe edge is placed by a programmable count given in reference-clock cycles. There is a read wait, a delay from chip select to output enable, and an output-enable hold before chip select rises. There is also a write wait before write enable falls, a write-enable width, an address-valid hold and a turnaround wait. A write always ends with one fixed cycle after write enable rises. The counts are sampled when a request is accepted. The block samples read data while output enable is still low and reports completion with a one-cycle pulse as chip select returns high. It then keeps chip select high for a turnaround gap before it accepts another request. A one-bit mode input sets when that gap applies.

All strobes are active low and registered, and they are held high during reset. A zero count gives the minimum timing.

Top module: `xmem_cycle_gen`

## Requirements
- R1: While reset is asserted and directly after it, mem_cs_n, mem_oe_n, mem_we_n and mem_adv_n are 1, mem_dq_oe and rsp_done are 0, and req_ready is 1.
- R2: A read holds mem_cs_n low for L = max(cfg_rd_wait+1, cfg_oe_setup+cfg_oe_hold+1) cycles. mem_cs_n falls on the clock edge that accepts the request (req_valid and req_ready both 1).
- R3: In a read, mem_oe_n is low exactly in the cycles with index k (k = 0 is the first cycle with chip select low) where cfg_oe_setup <= k < L - cfg_oe_hold. It is never low while mem_cs_n is high.
- R4: A write holds mem_cs_n low for cfg_wr_wait + cfg_we_len + 2 cycles. mem_we_n is low for cycle indices cfg_wr_wait through cfg_wr_wait + cfg_we_len, which leaves exactly one cycle of chip select low after write enable rises.
- R5: mem_adv_n falls together with mem_cs_n and is low for min(cfg_adv_hold+1, L) cycles of the access.
- R6: The value on mem_dq_i during the last cycle with mem_oe_n low is captured on the edge where mem_oe_n rises. It is then presented on rsp_rdata and held until the next read captures.
- R7: rsp_done is a single-cycle pulse that is high exactly in the first cycle after the access in which mem_cs_n is high again.
- R8: req_ready is low while mem_cs_n is low. Between accesses mem_cs_n stays high for 1 + G cycles when the next request is already waiting. G is cfg_ta_wait when cfg_ta_mode is 1 or the finished access was a read, and G is 0 otherwise.
- R9: mem_addr holds the accepted address for the whole access. mem_dq_oe is 1 exactly in the cycles of a write with mem_cs_n low, and mem_dq_o then carries the accepted write data.
- R10: mem_oe_n and mem_we_n are never low together. mem_oe_n stays high in writes and mem_we_n stays high in reads.
- R11: All cfg_* inputs are sampled on the accepting edge. Changing them during an access has no effect on that access or on the turnaround gap that follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, also the bus reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request can be accepted |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Last captured read data |
| cfg_rd_wait | input | CNT_W | Read chip-select wait count |
| cfg_oe_setup | input | CNT_W | Chip select to output enable delay |
| cfg_oe_hold | input | CNT_W | Output-enable rise to chip-select rise |
| cfg_wr_wait | input | CNT_W | Chip select to write enable delay |
| cfg_we_len | input | CNT_W | Write-enable low width minus one |
| cfg_adv_hold | input | CNT_W | Address-valid low width minus one |
| cfg_ta_wait | input | CNT_W | Turnaround wait count |
| cfg_ta_mode | input | 1 | 0: gap after reads only, 1: gap after every access |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_adv_n | output | 1 | Address valid, active low |
| mem_addr | output | ADDR_W | External address |
| mem_dq_o | output | DATA_W | External write data |
| mem_dq_oe | output | 1 | Data drive enable |
| mem_dq_i | input | DATA_W | External read data |

## Verification
The assertions assume that the cfg_* counts stay small enough for the longest access, 2*(2^CNT_W - 1) + 2 cycles, to fit the internal length width. They make no assumption about the settings being stable, because the sequencer samples them itself. They also assume that reset is held for at least one clock edge before the first request. The stimulus uses only 4-bit counts. It holds reset for several edges and changes every configuration input right after each acceptance, so the sample-once rule is exercised on every access. Requests are raised only on the falling clock edge, and the external read data is an index-coded pattern so that the capture cycle can be identified.

// File: rtl/xmem_cyc_pkg.sv
package xmem_cyc_pkg;

  // Internal width of cycle counts and lengths; fits CNT_W up to 6.
  localparam int LEN_W = 8;

  typedef logic [LEN_W-1:0] len_t;

  typedef enum logic [1:0] {
    SEQ_IDLE   = 2'd0,
    SEQ_ACCESS = 2'd1,
    SEQ_GAP    = 2'd2
  } seq_state_e;

  // Shape of one access: strobe windows as [lo, hi) cycle indices.
  typedef struct packed {
    len_t acc_len;
    len_t oe_lo;
    len_t oe_hi;
    len_t we_lo;
    len_t we_hi;
    len_t adv_hi;
    len_t gap_len;
    logic is_wr;
  } shape_t;

  // Read length: longer of the wait count and the OE setup+hold need.
  function automatic len_t f_read_len(len_t rdw, len_t su, len_t hd);
    len_t by_wait;
    len_t by_oe;
    by_wait = rdw + len_t'(1);
    by_oe   = su + hd + len_t'(1);
    return (by_wait > by_oe) ? by_wait : by_oe;
  endfunction

  // Write length: wait, WE width, and the fixed one-cycle tail.
  function automatic len_t f_write_len(len_t ww, len_t wl);
    return ww + wl + len_t'(2);
  endfunction

  function automatic logic f_in_win(len_t k, len_t lo, len_t hi);
    return (k >= lo) && (k < hi);
  endfunction

  // Turnaround gap after an access of the given direction.
  function automatic len_t f_gap(len_t ta, logic mode, logic was_wr);
    return (mode || !was_wr) ? ta : '0;
  endfunction

endpackage

// File: rtl/xmem_shape_unit.sv
module xmem_shape_unit
  import xmem_cyc_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             capture,
  input  logic             req_write,
  input  logic [CNT_W-1:0] cfg_rd_wait,
  input  logic [CNT_W-1:0] cfg_oe_setup,
  input  logic [CNT_W-1:0] cfg_oe_hold,
  input  logic [CNT_W-1:0] cfg_wr_wait,
  input  logic [CNT_W-1:0] cfg_we_len,
  input  logic [CNT_W-1:0] cfg_adv_hold,
  input  logic [CNT_W-1:0] cfg_ta_wait,
  input  logic             cfg_ta_mode,
  output shape_t           shape_eff
);

  function automatic len_t zx(logic [CNT_W-1:0] v);
    return len_t'(v);
  endfunction

  shape_t shape_new;
  shape_t shape_q;

  always_comb begin
    shape_new         = '0;
    shape_new.is_wr   = req_write;
    shape_new.adv_hi  = zx(cfg_adv_hold) + len_t'(1);
    shape_new.gap_len = f_gap(zx(cfg_ta_wait), cfg_ta_mode, req_write);
    if (req_write) begin
      shape_new.acc_len = f_write_len(zx(cfg_wr_wait), zx(cfg_we_len));
      shape_new.we_lo   = zx(cfg_wr_wait);
      shape_new.we_hi   = zx(cfg_wr_wait) + zx(cfg_we_len) + len_t'(1);
    end else begin
      shape_new.acc_len = f_read_len(zx(cfg_rd_wait), zx(cfg_oe_setup), zx(cfg_oe_hold));
      shape_new.oe_lo   = zx(cfg_oe_setup);
      shape_new.oe_hi   = shape_new.acc_len - zx(cfg_oe_hold);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shape_q <= '0;
    end else if (capture) begin
      shape_q <= shape_new;
    end
  end

  // Settings count from the accepting edge on; later input changes are ignored.
  assign shape_eff = capture ? shape_new : shape_q;

  assert_read_oe_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (capture && !req_write) |-> (shape_new.oe_hi > shape_new.oe_lo));

  assert_shape_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!capture && !$past(capture) && $past(rst_n)) |-> $stable(shape_q));

endmodule

// File: rtl/xmem_seq_ctrl.sv
module xmem_seq_ctrl
  import xmem_cyc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  len_t acc_len,
  input  len_t gap_len,
  output logic req_ready,
  output logic accept,
  output logic nxt_active,
  output len_t nxt_k,
  output logic last_cycle
);

  seq_state_e state, nxt_state;
  len_t       k_q;
  len_t       g_q, nxt_g;

  assign req_ready  = (state == SEQ_IDLE);
  assign accept     = req_valid && req_ready;
  assign last_cycle = (state == SEQ_ACCESS) && (k_q == acc_len - len_t'(1));

  always_comb begin
    nxt_state = state;
    nxt_k     = k_q;
    nxt_g     = g_q;
    unique case (state)
      SEQ_IDLE: begin
        if (accept) begin
          nxt_state = SEQ_ACCESS;
          nxt_k     = '0;
        end
      end
      SEQ_ACCESS: begin
        if (last_cycle) begin
          nxt_k = '0;
          if (gap_len != '0) begin
            nxt_state = SEQ_GAP;
            nxt_g     = gap_len;
          end else begin
            nxt_state = SEQ_IDLE;
          end
        end else begin
          nxt_k = k_q + len_t'(1);
        end
      end
      SEQ_GAP: begin
        if (g_q <= len_t'(1)) begin
          nxt_state = SEQ_IDLE;
          nxt_g     = '0;
        end else begin
          nxt_g = g_q - len_t'(1);
        end
      end
      default: nxt_state = SEQ_IDLE;
    endcase
  end

  assign nxt_active = (nxt_state == SEQ_ACCESS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SEQ_IDLE;
      k_q   <= '0;
      g_q   <= '0;
    end else begin
      state <= nxt_state;
      k_q   <= nxt_k;
      g_q   <= nxt_g;
    end
  end

  assert_access_bounded_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_ACCESS) |-> (k_q < acc_len));

  assert_gap_counts_down_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SEQ_GAP && g_q > len_t'(1)) |=> (state == SEQ_GAP));

endmodule

// File: rtl/xmem_pin_drv.sv
module xmem_pin_drv
  import xmem_cyc_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic              nxt_active,
  input  len_t              nxt_k,
  input  logic              last_cycle,
  input  shape_t            shape,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_adv_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata
);

  logic nxt_oe_low, nxt_we_low, nxt_adv_low, oe_closing;

  assign nxt_oe_low  = nxt_active && !shape.is_wr && f_in_win(nxt_k, shape.oe_lo, shape.oe_hi);
  assign nxt_we_low  = nxt_active &&  shape.is_wr && f_in_win(nxt_k, shape.we_lo, shape.we_hi);
  assign nxt_adv_low = nxt_active && (nxt_k < shape.adv_hi);
  // OE is low now and goes high on this edge: take the bus data.
  assign oe_closing  = !mem_oe_n && !nxt_oe_low;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_cs_n  <= 1'b1;
      mem_oe_n  <= 1'b1;
      mem_we_n  <= 1'b1;
      mem_adv_n <= 1'b1;
      mem_dq_oe <= 1'b0;
      rsp_done  <= 1'b0;
      mem_addr  <= '0;
      mem_dq_o  <= '0;
      rsp_rdata <= '0;
    end else begin
      mem_cs_n  <= !nxt_active;
      mem_oe_n  <= !nxt_oe_low;
      mem_we_n  <= !nxt_we_low;
      mem_adv_n <= !nxt_adv_low;
      mem_dq_oe <= nxt_active && shape.is_wr;
      rsp_done  <= last_cycle;
      if (accept) begin
        mem_addr <= req_addr;
        mem_dq_o <= req_wdata;
      end
      if (oe_closing) begin
        rsp_rdata <= mem_dq_i;
      end
    end
  end

  assert_oe_inside_cs_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_cs_n);

  assert_oe_we_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));

  assert_we_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> !mem_cs_n);

  assert_dq_drive_in_cs_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> !mem_cs_n);

endmodule

// File: rtl/xmem_cycle_gen.sv
module xmem_cycle_gen
  import xmem_cyc_pkg::*;
#(
  parameter int ADDR_W = 23,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [CNT_W-1:0]  cfg_rd_wait,
  input  logic [CNT_W-1:0]  cfg_oe_setup,
  input  logic [CNT_W-1:0]  cfg_oe_hold,
  input  logic [CNT_W-1:0]  cfg_wr_wait,
  input  logic [CNT_W-1:0]  cfg_we_len,
  input  logic [CNT_W-1:0]  cfg_adv_hold,
  input  logic [CNT_W-1:0]  cfg_ta_wait,
  input  logic              cfg_ta_mode,
  output logic              mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_adv_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_dq_o,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_i
);

  // Named internal events, shared by the sub-blocks and the assertions.
  logic   accept_evt;
  logic   nxt_active;
  len_t   nxt_k;
  logic   last_evt;
  shape_t shape_eff;

  xmem_shape_unit #(.CNT_W(CNT_W)) shape_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .capture      (accept_evt),
    .req_write    (req_write),
    .cfg_rd_wait  (cfg_rd_wait),
    .cfg_oe_setup (cfg_oe_setup),
    .cfg_oe_hold  (cfg_oe_hold),
    .cfg_wr_wait  (cfg_wr_wait),
    .cfg_we_len   (cfg_we_len),
    .cfg_adv_hold (cfg_adv_hold),
    .cfg_ta_wait  (cfg_ta_wait),
    .cfg_ta_mode  (cfg_ta_mode),
    .shape_eff    (shape_eff)
  );

  xmem_seq_ctrl seq_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .acc_len    (shape_eff.acc_len),
    .gap_len    (shape_eff.gap_len),
    .req_ready  (req_ready),
    .accept     (accept_evt),
    .nxt_active (nxt_active),
    .nxt_k      (nxt_k),
    .last_cycle (last_evt)
  );

  xmem_pin_drv #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) pins_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept     (accept_evt),
    .nxt_active (nxt_active),
    .nxt_k      (nxt_k),
    .last_cycle (last_evt),
    .shape      (shape_eff),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .mem_dq_i   (mem_dq_i),
    .mem_cs_n   (mem_cs_n),
    .mem_oe_n   (mem_oe_n),
    .mem_we_n   (mem_we_n),
    .mem_adv_n  (mem_adv_n),
    .mem_addr   (mem_addr),
    .mem_dq_o   (mem_dq_o),
    .mem_dq_oe  (mem_dq_oe),
    .rsp_done   (rsp_done),
    .rsp_rdata  (rsp_rdata)
  );

  assert_accept_drops_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> $fell(mem_cs_n));

  assert_adv_with_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_cs_n) |-> !mem_adv_n);

  assert_adv_inside_cs_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_adv_n |-> !mem_cs_n);

  assert_done_on_cs_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> $rose(mem_cs_n));

  assert_busy_not_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_cs_n |-> !req_ready);

  assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_cs_n && !$fell(mem_cs_n)) |-> $stable(mem_addr));

endmodule

// File: tb/xmem_cycle_gen_tb.sv
`timescale 1ns/1ps
module xmem_cycle_gen_tb_top;

  localparam int AW = 23;
  localparam int DW = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [CW-1:0] cfg_rd_wait = '0, cfg_oe_setup = '0, cfg_oe_hold = '0;
  logic [CW-1:0] cfg_wr_wait = '0, cfg_we_len = '0, cfg_adv_hold = '0, cfg_ta_wait = '0;
  logic          cfg_ta_mode = 1'b0;
  logic          mem_cs_n, mem_oe_n, mem_we_n, mem_adv_n, mem_dq_oe;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_o;
  logic [DW-1:0] mem_dq_i = 16'h5A5A;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_gap = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xmem_cycle_gen #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
    .cfg_rd_wait(cfg_rd_wait), .cfg_oe_setup(cfg_oe_setup), .cfg_oe_hold(cfg_oe_hold),
    .cfg_wr_wait(cfg_wr_wait), .cfg_we_len(cfg_we_len), .cfg_adv_hold(cfg_adv_hold),
    .cfg_ta_wait(cfg_ta_wait), .cfg_ta_mode(cfg_ta_mode),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n), .mem_adv_n(mem_adv_n),
    .mem_addr(mem_addr), .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  task automatic chk(string req, string what, longint got, longint exp);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // One access with its own expectations, derived from the requirement text.
  task automatic do_access(bit wr, logic [AW-1:0] addr, logic [DW-1:0] wd,
                           int rdw, int su, int hd, int ww, int wl,
                           int adv, int ta, bit tm);
    int len, hi, oe_from, oe_to, we_from, we_to, adv_n_cycles;
    req_write = wr; req_addr = addr; req_wdata = wd;
    cfg_rd_wait = CW'(rdw); cfg_oe_setup = CW'(su); cfg_oe_hold = CW'(hd);
    cfg_wr_wait = CW'(ww); cfg_we_len = CW'(wl); cfg_adv_hold = CW'(adv);
    cfg_ta_wait = CW'(ta); cfg_ta_mode = tm;
    req_valid = 1'b1;
    hi = 0;
    forever begin
      @(posedge clk); @(negedge clk);
      if (!mem_cs_n || hi > 60) break;
      hi++;
    end
    req_valid = 1'b0;
    // R11: scramble every setting right after acceptance.
    cfg_rd_wait = '1; cfg_oe_setup = '1; cfg_oe_hold = '1; cfg_wr_wait = '1;
    cfg_we_len = '1; cfg_adv_hold = '1; cfg_ta_wait = '1; cfg_ta_mode = ~tm;
    req_write = ~wr; req_addr = ~addr; req_wdata = ~wd;
    chk("R8", "turnaround high cycles beyond one", hi, exp_gap);
    if (wr) begin
      len = ww + wl + 2;
      oe_from = 0; oe_to = 0;
      we_from = ww; we_to = ww + wl + 1;
    end else begin
      len = rdw + 1;
      if (su + hd + 1 > len) len = su + hd + 1;
      oe_from = su; oe_to = len - hd;
      we_from = 0; we_to = 0;
    end
    adv_n_cycles = (adv + 1 < len) ? adv + 1 : len;
    for (int i = 0; i <= len; i++) begin
      if (i > 0) begin @(posedge clk); @(negedge clk); end
      chk(wr ? "R4" : "R2", "cs_n", mem_cs_n, (i < len) ? 0 : 1);
      chk(wr ? "R10" : "R3", "oe_n", mem_oe_n, (i >= oe_from && i < oe_to) ? 0 : 1);
      chk(wr ? "R4" : "R10", "we_n", mem_we_n, (i >= we_from && i < we_to) ? 0 : 1);
      chk("R5", "adv_n", mem_adv_n, (i < adv_n_cycles) ? 0 : 1);
      chk("R7", "done", rsp_done, (i == len) ? 1 : 0);
      chk("R9", "dq_oe", mem_dq_oe, (wr && i < len) ? 1 : 0);
      if (i < len) chk("R8", "ready while busy", req_ready, 0);
      if (i == 0 || i == len - 1) chk("R9", "addr", mem_addr, addr);
      if (wr && i == 0) chk("R9", "dq_o", mem_dq_o, wd);
      if (!wr && i == len) chk("R6", "rdata", rsp_rdata, 16'hC000 + (len - hd - 1));
      mem_dq_i = 16'hC000 + DW'(i);
    end
    exp_gap = (tm || !wr) ? ta : 0;
  endtask

  task automatic t_reset();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "cs_n in reset", mem_cs_n, 1);
    chk("R1", "oe_n in reset", mem_oe_n, 1);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk("R1", "we_n", mem_we_n, 1);
    chk("R1", "adv_n", mem_adv_n, 1);
    chk("R1", "dq_oe", mem_dq_oe, 0);
    chk("R1", "done", rsp_done, 0);
    chk("R1", "ready", req_ready, 1);
  endtask

  task automatic t_reads();
    do_access(0, 23'h012345, 16'h0, 5, 1, 1, 0, 0, 2, 0, 0);  // R2 R3 basic
    do_access(0, 23'h000001, 16'h0, 0, 0, 0, 0, 0, 0, 0, 0);  // minimum read
    do_access(0, 23'h7FFFFF, 16'h0, 1, 3, 2, 0, 0, 15, 0, 0); // OE need stretches CS, ADV clamp
  endtask

  task automatic t_writes();
    do_access(1, 23'h00ABCD, 16'hBEEF, 0, 0, 0, 2, 3, 1, 0, 0); // R4 basic
    do_access(1, 23'h055555, 16'h1234, 9, 9, 9, 0, 0, 0, 0, 0); // minimum write, read counts ignored
    do_access(1, 23'h2AAAAA, 16'hFFFF, 0, 0, 0, 5, 0, 9, 0, 0);
  endtask

  task automatic t_turnaround();
    do_access(0, 23'h000010, 16'h0, 2, 0, 0, 0, 0, 0, 3, 0); // read, mode 0: gap 3
    do_access(0, 23'h000011, 16'h0, 2, 1, 0, 0, 0, 0, 0, 0);
    do_access(1, 23'h000012, 16'hA5A5, 0, 0, 0, 1, 1, 0, 4, 0); // write, mode 0: no gap
    do_access(1, 23'h000013, 16'h5A5A, 0, 0, 0, 1, 1, 0, 2, 1); // write, mode 1: gap 2
    do_access(0, 23'h000014, 16'h0, 3, 1, 1, 0, 0, 1, 2, 0);    // read: gap 2
    do_access(1, 23'h000015, 16'h0F0F, 0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    t_reset();
    t_reads();
    t_writes();
    t_turnaround();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule